// File: doc/BRIEF.md
# Windowed Watchdog Timer

A watchdog whose 7-bit counter counts down from a software-loaded value and must be reloaded inside a time window. Too late, and the counter drops out of its upper half. Too early, and the counter is still above a programmed window value. Either case, and a reload with a value already in the lower half, raises a one-cycle reset request while the watchdog is armed. A fixed power-of-two divider followed by a selectable divide of 1, 2, 4 or 8 sets how fast the counter falls. Hardware raises a warning flag one step before expiry, and this flag can drive an interrupt.

Software reaches three word registers over a simple write-strobe bus with a combinational read port. `ctrl` (0x0) holds the counter in bits 6:0 and the arm bit in bit 7. `cfg` (0x4) holds the window in bits 6:0, the rate select in bits 8:7 and the interrupt enable in bit 9. `stat` (0x8) holds the warning flag in bit 0. Unmapped offsets read zero.

Top module: `window_watchdog`

## Requirements
- R1: After reset, ctrl reads 0x07F, cfg reads 0x07F, stat reads 0, and irq_o and rst_req_o are low.
- R2: The counter falls by one every 2^(DIV_LOG2+s) clocks, where s is cfg bits 8:7. It wraps from 0x00 to 0x7F and is otherwise unchanged between steps.
- R3: The arm bit (ctrl bit 7) can only be set by a ctrl write with bit 7 at 1. A write with bit 7 at 0 leaves it set, and only reset clears it.
- R4: While armed, the counter stepping from 0x40 to 0x3F raises rst_req_o for exactly one cycle, on the clock after the step.
- R5: While armed, including by the same write, a ctrl write whose bit 6 is 0 raises rst_req_o for one cycle.
- R6: While armed, a ctrl write made while the current counter is greater than the window raises rst_req_o for one cycle. A write with the counter at or below the window does not.
- R7: The warning flag (stat bit 0) is set when the counter steps from 0x41 to 0x40, whatever the interrupt enable.
- R8: Writing stat with bit 0 at 0 clears the flag. Writing it with bit 0 at 1 leaves the flag unchanged.
- R9: The interrupt enable (cfg bit 9) can be set but not cleared by writes. irq_o is high exactly while the flag and the enable are both set.
- R10: A ctrl write restarts the rate divider, so the next step comes a full period after the write.
- R11: While not armed, the counter and divider keep running and rst_req_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The hardest conditions to reach are the timed ones: a reload that lands just above or at the window, and the exact clock on which the counter leaves 0x40 while the interrupt enable and the arm bit are set. The bench runs with a small divider. It moves the window to 0x70 and reloads both right after writing it and after enough steps have passed for the counter to sink below it. It then lets the counter run down unattended, so the warning, the interrupt and the single expiry pulse occur in sequence. A cycle-by-cycle behavioural model tracks every register and both outputs throughout.

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int DIV_LOG2 = 12,
  parameter int CW = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        rst_req_o
);
  localparam int PW = DIV_LOG2 + 3;
  localparam logic [CW-1:0] MID = CW'(1 << (CW - 1));
  localparam logic [3:0] A_CTRL = 4'h0, A_CFG = 4'h4, A_STAT = 4'h8;

  logic          armed, ie, flag, req_q;
  logic [CW-1:0] cnt, win;
  logic [1:0]    rate;
  logic [PW-1:0] ph, mask;

  wire ctrl_wr = bus_wr && bus_addr == A_CTRL;
  wire cfg_wr  = bus_wr && bus_addr == A_CFG;
  wire stat_wr = bus_wr && bus_addr == A_STAT;

  assign mask = {PW{1'b1}} >> (2'd3 - rate);
  wire tick     = (ph & mask) == mask;
  wire step     = tick && !ctrl_wr;
  wire armed_nx = armed | (ctrl_wr & bus_wdata[CW]);
  wire bad_wr   = ctrl_wr && armed_nx && (!bus_wdata[CW-1] || cnt > win);
  wire expire   = armed && step && cnt == MID;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      ie    <= 1'b0;
      flag  <= 1'b0;
      req_q <= 1'b0;
      cnt   <= '1;
      win   <= '1;
      rate  <= '0;
      ph    <= '0;
    end else begin
      req_q <= bad_wr | expire;
      armed <= armed_nx;
      ph    <= ctrl_wr ? '0 : ph + 1'b1;
      if (ctrl_wr)   cnt <= bus_wdata[CW-1:0];
      else if (tick) cnt <= cnt - 1'b1;
      if (cfg_wr) begin
        win  <= bus_wdata[CW-1:0];
        rate <= bus_wdata[CW+1:CW];
        ie   <= ie | bus_wdata[CW+2];
      end
      if (step && cnt == MID + 1'b1)  flag <= 1'b1;
      else if (stat_wr && !bus_wdata[0]) flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[CW:0]   = {armed, cnt};
      A_CFG:  bus_rdata[CW+2:0] = {ie, rate, win};
      A_STAT: bus_rdata[0]      = flag;
      default: ;
    endcase
  end

  assign irq_o     = flag & ie;
  assign rst_req_o = req_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !tick) |=> $stable(cnt));
  p_arm_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  p_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && step && cnt == MID) |=> rst_req_o);
  p_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && armed && cnt > win) |=> rst_req_o);
  p_warn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == MID + 1'b1) |=> flag);
  p_ie_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ie |=> ie);
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> armed);
endmodule

// File: tb/test_window_watchdog.sv
module test_window_watchdog;
  localparam int CLK = 10;
  localparam int DL = 2;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq_o, rst_req_o;
  int checks = 0, errors = 0, pulses = 0;
  int m_cnt, m_win, m_tb, m_en, m_ie, m_flag, m_ph, m_req;

  always #(CLK/2) clk = ~clk;

  window_watchdog #(.DIV_LOG2(DL)) i_window_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 127; m_win = 127; m_tb = 0; m_en = 0; m_ie = 0; m_flag = 0; m_ph = 0; m_req = 0;
    end else begin
      int per, en_n;
      bit tk, cw, fw, sw;
      per = 1 << (DL + m_tb);
      tk = (m_ph % per) == per - 1;
      cw = bus_wr && bus_addr == 0;
      fw = bus_wr && bus_addr == 4;
      sw = bus_wr && bus_addr == 8;
      en_n = m_en | int'(cw && bus_wdata[7]);
      m_req = int'((cw && en_n != 0 && (!bus_wdata[6] || m_cnt > m_win)) ||
                   (!cw && tk && m_en != 0 && m_cnt == 64));
      if (!cw && tk && m_cnt == 65) m_flag = 1;
      else if (sw && !bus_wdata[0]) m_flag = 0;
      if (cw) m_cnt = int'(bus_wdata[6:0]);
      else if (tk) m_cnt = (m_cnt + 127) % 128;
      m_ph = cw ? 0 : (m_ph + 1) % (1 << (DL + 3));
      if (fw) begin
        m_win = int'(bus_wdata[6:0]);
        m_tb = int'(bus_wdata[8:7]);
        m_ie = m_ie | int'(bus_wdata[9]);
      end
      m_en = en_n;
    end
  end

  always @(posedge clk) begin
    #(CLK/4);
    if (rst_n) begin
      int exp;
      case (bus_addr)
        0: exp = (m_en << 7) | m_cnt;
        4: exp = (m_ie << 9) | (m_tb << 7) | m_win;
        8: exp = m_flag;
        default: exp = 0;
      endcase
      chk("R2 model read", int'(bus_rdata), exp);
      chk("R4 model rst_req", int'(rst_req_o), m_req);
      chk("R9 model irq", int'(irq_o), m_flag & m_ie);
      if (rst_req_o) pulses++;
    end
  end

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk); bus_addr = a; #1 v = int'(bus_rdata);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, p0;
    wait_cyc(3);
    rst_n = 1;
    rd(4'h0, v); chk("R1 ctrl", v, 'h7F);
    rd(4'h4, v); chk("R1 cfg", v, 'h7F);
    rd(4'h8, v); chk("R1 stat", v, 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 rst_req", int'(rst_req_o), 0);

    wait_cyc(600);
    chk("R11 no pulse when disarmed", pulses, 0);
    wr(4'h0, 'h7F);
    rd(4'h8, v); chk("R7 flag set with ie off", v, 1);
    chk("R7 irq stays low", int'(irq_o), 0);
    wr(4'h8, 1);
    rd(4'h8, v); chk("R8 write one keeps flag", v, 1);
    wr(4'h8, 0);
    rd(4'h8, v); chk("R8 write zero clears", v, 0);

    wr(4'h4, (2 << 7) | 'h7F);
    wr(4'h0, 'h7F);
    wait_cyc(10);
    wr(4'h0, 'h7F);
    wait_cyc(14);
    rd(4'h0, v); chk("R10 no step before full period", v, 'h7F);
    rd(4'h0, v); chk("R2 step after 16 clocks", v, 'h7E);

    wr(4'h4, 'h7F);
    wr(4'h0, 'hFF);
    rd(4'h0, v); chk("R3 armed", v >> 7, 1);
    wr(4'h0, 'h7F);
    rd(4'h0, v); chk("R3 write zero keeps arm", v >> 7, 1);
    chk("R6 refresh within window no pulse", pulses, 0);

    p0 = pulses;
    wr(4'h0, 'h3F);
    wait_cyc(1);
    chk("R5 low value write pulse", pulses, p0 + 1);
    wr(4'h0, 'h7F);
    wr(4'h4, 'h70);
    p0 = pulses;
    wr(4'h0, 'h7F);
    wait_cyc(1);
    chk("R6 early refresh pulse", pulses, p0 + 1);
    wait_cyc(100);
    p0 = pulses;
    wr(4'h0, 'h7F);
    wait_cyc(1);
    chk("R6 late refresh no pulse", pulses, p0);

    wr(4'h4, (1 << 9) | 'h70);
    p0 = pulses;
    wait_cyc(250);
    chk("R9 irq asserted at warning", int'(irq_o), 1);
    chk("R4 no pulse before expiry", pulses, p0);
    wait_cyc(12);
    chk("R4 single expiry pulse", pulses, p0 + 1);
    wr(4'h4, 'h70);
    rd(4'h4, v); chk("R9 ie sticky", v >> 9, 1);

    wait_cyc(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule